// File: doc/BRIEF.md
# Linked List Ranker with Stair-Step Rank Lines

This block takes a singly linked list of N elements and reports, for every element, its position in the list counted from the head. Each element is presented in its own slot with a successor index and a head flag. The tail is marked by a successor index equal to its own slot number. After a start pulse the block latches the list and runs for a fixed number of clock cycles. It then raises done and holds a rank per slot until the next accepted start.

Inside, every element owns a bundle of N one-bit rank lines, one for each possible rank. Line r of an element feeds line r+1 of the bundle belonging to its successor. A token is injected on line 0 of the head's bundle. The switched-bus fusion of a reconfigurable grid is replaced by clocked relaxation: in each cycle every line takes the OR of its diagonal feeders. After N cycles the token has reached the tail. The index of the line that carries the token in a bundle is that element's rank.

Top module: `lr_ranker`

## Requirements
- R1: While reset is asserted and after it is released, done, busy and err read 0 and every rank field reads 0.
- R2: Successor index i sits in succ_in bits [i*IW +: IW] and head flag i in head_in bit i. A successor index equal to its own slot marks the tail, and the tail makes no onward link.
- R3: For a well-formed list, the head reports rank 0 and the tail reports rank N-1. Each other element reports its predecessor's rank plus one, in rank_out bits [i*IW +: IW].
- R4: A start sampled while the block is not busy is accepted. Busy is 1 from the next edge. Done rises on the N-th clock edge after the edge that accepted start, and busy falls on that same edge.
- R5: Done stays high, and ranks and err stay unchanged, until the next accepted start. Changes on succ_in and head_in after acceptance do not alter the result.
- R6: A start pulse while busy is ignored. It does not affect the ranks produced or the cycle on which done rises.
- R7: If no head flag is set at an accepted start, err is 1 when done rises and every rank field reads 0. A later start with a head clears err.
- R8: Each accepted start discards the previous result, and done reads 0 while the new run is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to latch the list and rank it |
| succ_in | input | N*IW | Successor index per slot, IW bits each |
| head_in | input | N | Head flag per slot |
| busy | output | 1 | Ranking in progress |
| done | output | 1 | Ranks valid; held until next accepted start |
| err | output | 1 | No head flag was set at the accepted start |
| rank_out | output | N*IW | Rank per slot, IW bits each |

## Verification
The hardest condition to produce from the ports is a second start arriving mid-run with a different list. It must leave both the result and the completion cycle untouched. The bench drives it directly by raising start with a fresh list a few cycles into a run, then checks the ranks of the first list and the completion latency. Random permutations built from a fixed seed cover long chains in which the tail sits at an arbitrary slot. Directed cases cover the identity order, the reversed order and a list with no head.

// File: rtl/lr_pkg.sv
package lr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } lr_state_e;
endpackage

// File: rtl/lr_ctrl.sv
module lr_ctrl #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic no_head,
  output logic load,
  output logic step,
  output logic busy,
  output logic done,
  output logic err
);
  import lr_pkg::*;

  localparam logic [IW-1:0] LAST_STEP = IW'(N - 1);

  lr_state_e st_q, st_d;
  logic [IW-1:0] cnt_q, cnt_d;
  logic err_q, err_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    err_d = err_q;
    load  = 1'b0;
    case (st_q)
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_STEP) begin
          st_d  = ST_DONE;
          cnt_d = '0;
        end
      end
      default: begin
        if (start) begin
          load  = 1'b1;
          st_d  = ST_RUN;
          cnt_d = '0;
          err_d = no_head;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign step = (st_q == ST_RUN);
  assign busy = (st_q == ST_RUN);
  assign done = (st_q == ST_DONE);
  assign err  = err_q & (st_q == ST_DONE);
endmodule

// File: rtl/lr_bundle.sv
module lr_bundle #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1,
  parameter int J  = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic            head_bit,
  input  logic [N*IW-1:0] succ_q,
  input  logic [N*N-1:0]  lines_all,
  output logic [N-1:0]    lines
);
  localparam logic [IW-1:0] SELF = IW'(J);

  logic [N-1:0] feed;
  logic [N-1:0] lines_d;

  always_comb begin
    feed    = '0;
    feed[0] = head_bit;
    for (int i = 0; i < N; i++) begin
      if ((succ_q[i*IW +: IW] == SELF) && (succ_q[i*IW +: IW] != IW'(i))) begin
        for (int r = 1; r < N; r++) begin
          feed[r] = feed[r] | lines_all[i*N + r - 1];
        end
      end
    end
  end

  always_comb begin
    if (clr)     lines_d = '0;
    else if (en) lines_d = lines | feed;
    else         lines_d = lines;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lines <= '0;
    else        lines <= lines_d;
  end
endmodule

// File: rtl/lr_rank_enc.sv
module lr_rank_enc #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  lines,
  output logic [IW-1:0] rank
);
  always_comb begin
    rank = '0;
    for (int r = N - 1; r >= 0; r--) begin
      if (lines[r]) rank = IW'(r);
    end
  end
endmodule

// File: rtl/lr_ranker.sv
module lr_ranker #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [N*IW-1:0] succ_in,
  input  logic [N-1:0]    head_in,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [N*IW-1:0] rank_out
);
  logic            load, step;
  logic [N*IW-1:0] succ_q, succ_d;
  logic [N-1:0]    head_q, head_d;
  logic [N*N-1:0]  lines_all;

  lr_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .no_head (~|head_in),
    .load    (load),
    .step    (step),
    .busy    (busy),
    .done    (done),
    .err     (err)
  );

  always_comb begin
    succ_d = load ? succ_in : succ_q;
    head_d = load ? head_in : head_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      succ_q <= '0;
      head_q <= '0;
    end else begin
      succ_q <= succ_d;
      head_q <= head_d;
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_elem
    lr_bundle #(.N(N), .IW(IW), .J(j)) u_bundle (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (load),
      .en        (step),
      .head_bit  (head_q[j]),
      .succ_q    (succ_q),
      .lines_all (lines_all),
      .lines     (lines_all[j*N +: N])
    );
    lr_rank_enc #(.N(N), .IW(IW)) u_enc (
      .lines (lines_all[j*N +: N]),
      .rank  (rank_out[j*IW +: IW])
    );
  end
endmodule

// File: rtl/lr_ranker_chk.sv
module lr_ranker_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic [N*N-1:0] lines_all
);
  // R4
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R8
  accept_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  // R5
  done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(err) && $stable(lines_all)));

  // R3
  lines_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((lines_all & $past(lines_all)) == $past(lines_all)));

  // R7
  no_head_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (lines_all == '0));

  // R6
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind lr_ranker lr_ranker_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .lines_all (lines_all)
);

// File: tb/lr_ranker_test.sv
module lr_ranker_test;
  localparam int N  = 8;
  localparam int IW = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic [N*IW-1:0] succ_in;
  logic [N-1:0]    head_in;
  logic            busy, done, err;
  logic [N*IW-1:0] rank_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  lr_ranker #(.N(N), .IW(IW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .succ_in(succ_in),
    .head_in(head_in), .busy(busy), .done(done), .err(err), .rank_out(rank_out)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // build list from visiting order; order[0] is head
  task automatic build(input int order[N], output logic [N*IW-1:0] s,
                       output logic [N-1:0] h);
    s = '0; h = '0;
    h[order[0]] = 1'b1;
    for (int k = 0; k < N; k++) begin
      if (k == N - 1) s[order[k]*IW +: IW] = IW'(order[k]);
      else            s[order[k]*IW +: IW] = IW'(order[k+1]);
    end
  endtask

  // serial walk reference
  task automatic walk(input logic [N*IW-1:0] s, input logic [N-1:0] h,
                      output int rk[N]);
    int cur;
    for (int i = 0; i < N; i++) rk[i] = 0;
    cur = -1;
    for (int i = 0; i < N; i++) if (h[i] && cur < 0) cur = i;
    if (cur >= 0) begin
      for (int k = 0; k < N; k++) begin
        int nx;
        rk[cur] = k;
        nx = int'(s[cur*IW +: IW]);
        if (nx == cur) break;
        cur = nx;
      end
    end
  endtask

  task automatic run(input logic [N*IW-1:0] s, input logic [N-1:0] h,
                     input bit inj, input logic [N*IW-1:0] s2,
                     input logic [N-1:0] h2, output int lat, output bit bz);
    @(negedge clk);
    succ_in = s; head_in = h; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    bz  = busy;
    lat = 0;
    while (!done && lat < 4*N) begin
      if (inj && lat == 2) begin
        start = 1'b1; succ_in = s2; head_in = h2;
      end else begin
        start = 1'b0;
      end
      @(posedge clk); @(negedge clk);
      lat++;
    end
    start = 1'b0;
  endtask

  task automatic compare(input string tag, input int rk[N]);
    for (int i = 0; i < N; i++)
      check(tag, int'(rank_out[i*IW +: IW]), rk[i]);
  endtask

  initial begin
    int order[N];
    int rk[N];
    logic [N*IW-1:0] s, s2;
    logic [N-1:0] h, h2;
    int lat;
    bit bz;
    int seed;
    logic [N*IW-1:0] keep;

    seed = $urandom(32'd1234);
    rst_n = 1'b0; start = 1'b0; succ_in = '0; head_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check("R1 done", int'(done), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 err", int'(err), 0);
    check("R1 ranks", int'(rank_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after release", int'(done), 0);

    // identity order: slot i has rank i (R2, R3, R4)
    for (int k = 0; k < N; k++) order[k] = k;
    build(order, s, h);
    walk(s, h, rk);
    run(s, h, 1'b0, '0, '0, lat, bz);
    check("R4 busy after accept", int'(bz), 1);
    check("R4 latency", lat, N);
    check("R2 err", int'(err), 0);
    compare("R3 identity", rk);

    // R5: input changes after done do not alter result
    keep = rank_out;
    succ_in = '1; head_in = '1;
    repeat (3) @(negedge clk);
    check("R5 done held", int'(done), 1);
    check("R5 ranks held", int'(rank_out == keep), 1);

    // reversed order: tail at slot 0 (R2 tail self-pointer)
    for (int k = 0; k < N; k++) order[k] = N - 1 - k;
    build(order, s, h);
    walk(s, h, rk);
    run(s, h, 1'b0, '0, '0, lat, bz);
    check("R8 busy on new run", int'(bz), 1);
    compare("R3 reversed", rk);
    check("R2 tail slot0 rank", int'(rank_out[0 +: IW]), N - 1);

    // R7: no head
    run(s, '0, 1'b0, '0, '0, lat, bz);
    check("R7 latency", lat, N);
    check("R7 err", int'(err), 1);
    check("R7 ranks zero", int'(rank_out), 0);

    // R7/R8: next good start clears err
    for (int k = 0; k < N; k++) order[k] = (k * 3) % N;
    build(order, s, h);
    walk(s, h, rk);
    run(s, h, 1'b0, '0, '0, lat, bz);
    check("R7 err cleared", int'(err), 0);
    compare("R8 stride list", rk);

    // R6: start while busy with another list is ignored
    for (int k = 0; k < N; k++) order[k] = (k + 5) % N;
    build(order, s, h);
    walk(s, h, rk);
    for (int k = 0; k < N; k++) order[k] = N - 1 - k;
    build(order, s2, h2);
    run(s, h, 1'b1, s2, h2, lat, bz);
    check("R6 latency unchanged", lat, N);
    compare("R6 ranks of first list", rk);
    @(negedge clk);
    check("R6 no restart", int'(busy), 0);

    // random permutations
    for (int t = 0; t < 24; t++) begin
      for (int k = 0; k < N; k++) order[k] = k;
      for (int k = N - 1; k > 0; k--) begin
        int j, tmp;
        j = int'($urandom % (k + 1));
        tmp = order[k]; order[k] = order[j]; order[j] = tmp;
      end
      build(order, s, h);
      walk(s, h, rk);
      run(s, h, 1'b0, '0, '0, lat, bz);
      check("R4 random latency", lat, N);
      compare("R3 random", rk);
    end

    summary();
    $finish;
  end
endmodule